// File: doc/BRIEF.md
# Orientation and Shake Event Detector

The block watches a stream of signed 8-bit X and Y acceleration readings, each qualified by a valid strobe. For every reading it picks one of four orientation quadrants and notes whether the device is lying too flat to judge orientation at all. The reported orientation changes only after a programmable number of consecutive readings that agree with each other and differ from the current one. Alongside this it looks for shakes: a run of readings in which X goes past a programmable threshold in one direction, with a programmable run length.

Every output is registered. The reported orientation, the one before it, a tilt-invalid flag, a two-bit shake code and a sticky interrupt flag change on the clock edge that accepts the deciding reading. A power-down input makes the block ignore readings. A one-cycle clear input, pulsed for example when software reads the status, drops the interrupt and the shake code.

Top module: `orient_shake_det`

## Requirements
- R1: After reset, orient_cur and orient_prev are 00 and tilt_bad, shake_code and irq are all 0.
- R2: The raw quadrant of a reading comes from the axis with the larger magnitude, with Y winning a tie. If Y dominates, it is 00 (upright) for Y >= 0 and 10 (inverted) for Y < 0. If X dominates, it is 01 (rotated clockwise) for X > 0 and 11 (rotated counterclockwise) for X < 0.
- R3: orient_cur takes a new quadrant on the edge that accepts the Nth consecutive accepted reading of that quadrant, with N = 16 << orc_sel (16, 32, 64 or 128). A reading of the current quadrant or of another quadrant restarts the run.
- R4: Whenever orient_cur changes, orient_prev takes the value orient_cur held before.
- R5: A reading with both |X| < 32 and |Y| < 32 sets tilt_bad to 1, and any other accepted reading clears it. Such a reading neither advances nor breaks the orientation run.
- R6: The shake threshold is 32 * (shth_sel + 1) LSB, with 1g = 64 LSB. X < -threshold counts toward a left shake (code 01) and X > threshold toward a right shake (code 10). A reading exactly at the threshold does not count, and code 11 is never produced.
- R7: A shake event fires on the Mth consecutive accepted reading over the threshold in the same direction, with M = 16 << shc_sel. A reading under the threshold or in the other direction restarts the run. The event writes its direction to shake_code.
- R8: While pwr_down is 1, readings are ignored: orientation, tilt and shake state hold.
- R9: irq is set by an orientation change or a shake event and stays set until int_clr. int_clr also returns shake_code to 00. A new event in the same cycle as int_clr wins.
- R10: Cycles with smp_valid at 0 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Reading strobe |
| x_in | input | 8 | X acceleration, two's complement |
| y_in | input | 8 | Y acceleration, two's complement |
| pwr_down | input | 1 | Ignore readings while high |
| orc_sel | input | 2 | Orientation run length code |
| shth_sel | input | 2 | Shake threshold code |
| shc_sel | input | 2 | Shake run length code |
| int_clr | input | 1 | One-cycle clear of irq and shake_code |
| orient_cur | output | 2 | Debounced orientation |
| orient_prev | output | 2 | Orientation before the last change |
| tilt_bad | output | 1 | Orientation not valid for the last reading |
| shake_code | output | 2 | Last shake direction |
| irq | output | 1 | Sticky event flag |

## Verification
A run counter or candidate register holding a wrong value does not show up right away. It appears at the ports as orient_cur or shake_code changing one or more readings early or late. The bench therefore compares every output after every reading, so an off-by-one run shows within the same reading that should or should not have moved it. A full sweep over all X and Y pairs exercises the quadrant boundaries and the tilt boundaries. Directed runs that are cut short by one reading catch restart faults at exactly N-1 and N.

// File: rtl/osd_pkg.sv
package osd_pkg;
  typedef logic [1:0] quad_t;
  localparam quad_t QUAD_UP  = 2'b00;
  localparam quad_t QUAD_CW  = 2'b01;
  localparam quad_t QUAD_INV = 2'b10;
  localparam quad_t QUAD_CCW = 2'b11;

  typedef logic [1:0] shk_t;
  localparam shk_t SHK_NONE  = 2'b00;
  localparam shk_t SHK_LEFT  = 2'b01;
  localparam shk_t SHK_RIGHT = 2'b10;
endpackage

// File: rtl/osd_classify.sv
module osd_classify
  import osd_pkg::*;
#(
  parameter int W     = 8,
  parameter int MAG_W = W + 1,
  parameter int ONE_G = 64
) (
  input  logic [W-1:0]     x,
  input  logic [W-1:0]     y,
  input  logic [MAG_W-1:0] thr,
  output quad_t            raw,
  output logic             tilt,
  output logic             over_l,
  output logic             over_r
);
  localparam logic [MAG_W-1:0] TILT_LIM = MAG_W'(ONE_G / 2);

  logic [MAG_W-1:0] xs, ys, ax, ay;

  always_comb begin
    xs = {x[W-1], x};
    ys = {y[W-1], y};
    ax = x[W-1] ? (~xs + MAG_W'(1)) : xs;
    ay = y[W-1] ? (~ys + MAG_W'(1)) : ys;
    if (ay >= ax) raw = y[W-1] ? QUAD_INV : QUAD_UP;
    else          raw = x[W-1] ? QUAD_CCW : QUAD_CW;
    tilt   = (ax < TILT_LIM) && (ay < TILT_LIM);
    over_l = x[W-1]  && (ax > thr);
    over_r = !x[W-1] && (ax > thr);
  end
endmodule

// File: rtl/osd_debounce.sv
module osd_debounce
  import osd_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic             tilt,
  input  quad_t            raw,
  input  logic [CNT_W-1:0] lim,
  output quad_t            cur_q,
  output quad_t            prev_q,
  output logic             tilt_q,
  output logic             chg_ev
);
  quad_t            cand_q;
  logic [CNT_W-1:0] run_q, run_nxt;

  always_comb begin
    run_nxt = run_q + CNT_W'(1);
    chg_ev  = take && !tilt && (raw != cur_q) && (raw == cand_q) && (run_nxt >= lim);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q  <= QUAD_UP;
      prev_q <= QUAD_UP;
      cand_q <= QUAD_UP;
      run_q  <= '0;
      tilt_q <= 1'b0;
    end else if (take) begin
      tilt_q <= tilt;
      if (!tilt) begin
        if (raw == cur_q) begin
          run_q <= '0;
        end else if (raw == cand_q) begin
          if (chg_ev) begin
            prev_q <= cur_q;
            cur_q  <= raw;
            run_q  <= '0;
          end else begin
            run_q <= run_nxt;
          end
        end else begin
          cand_q <= raw;
          run_q  <= CNT_W'(1);
        end
      end
    end
  end

  a_r4_prev_follows: assert property (@(posedge clk) disable iff (rst)
    !$stable(cur_q) |-> prev_q == $past(cur_q));
  a_r3_change_needs_reading: assert property (@(posedge clk) disable iff (rst)
    !$stable(cur_q) |-> $past(take && !tilt));
  a_r5_tilt_holds_run: assert property (@(posedge clk) disable iff (rst)
    take && tilt |=> $stable(run_q) && $stable(cand_q));
endmodule

// File: rtl/osd_shake.sv
module osd_shake
  import osd_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic             over_l,
  input  logic             over_r,
  input  logic [CNT_W-1:0] lim,
  output logic             shk_ev,
  output shk_t             shk_dir
);
  shk_t             dir_q;
  logic [CNT_W-1:0] run_q, run_nxt;

  always_comb begin
    if (over_l)      shk_dir = SHK_LEFT;
    else if (over_r) shk_dir = SHK_RIGHT;
    else             shk_dir = SHK_NONE;
    run_nxt = (shk_dir == dir_q) ? run_q + CNT_W'(1) : CNT_W'(1);
    shk_ev  = take && (shk_dir != SHK_NONE) && (run_nxt >= lim);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= SHK_NONE;
      run_q <= '0;
    end else if (take) begin
      if (shk_dir != SHK_NONE) begin
        dir_q <= shk_dir;
        run_q <= shk_ev ? '0 : run_nxt;
      end else begin
        run_q <= '0;
      end
    end
  end

  a_r7_event_needs_excursion: assert property (@(posedge clk) disable iff (rst)
    shk_ev |-> take && (over_l || over_r));
  a_r6_one_direction: assert property (@(posedge clk) disable iff (rst)
    !(over_l && over_r));
endmodule

// File: rtl/orient_shake_det.sv
module orient_shake_det
  import osd_pkg::*;
#(
  parameter int W        = 8,
  parameter int ONE_G    = 64,
  parameter int BASE_CNT = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         smp_valid,
  input  logic [W-1:0] x_in,
  input  logic [W-1:0] y_in,
  input  logic         pwr_down,
  input  logic [1:0]   orc_sel,
  input  logic [1:0]   shth_sel,
  input  logic [1:0]   shc_sel,
  input  logic         int_clr,
  output logic [1:0]   orient_cur,
  output logic [1:0]   orient_prev,
  output logic         tilt_bad,
  output logic [1:0]   shake_code,
  output logic         irq
);
  localparam int MAG_W = W + 1;
  localparam int CNT_W = $clog2(BASE_CNT * 8 + 1);

  logic             take;
  logic [MAG_W-1:0] thr;
  logic [CNT_W-1:0] orc_lim, shc_lim;
  quad_t            raw;
  logic             tilt, over_l, over_r, chg_ev, shk_ev;
  shk_t             shk_dir;

  always_comb begin
    take    = smp_valid && !pwr_down;
    orc_lim = CNT_W'(BASE_CNT) << orc_sel;
    shc_lim = CNT_W'(BASE_CNT) << shc_sel;
    thr     = MAG_W'(ONE_G / 2) * ({{(MAG_W-2){1'b0}}, shth_sel} + MAG_W'(1));
  end

  osd_classify #(.W(W), .MAG_W(MAG_W), .ONE_G(ONE_G)) u_cls (
    .x(x_in), .y(y_in), .thr(thr),
    .raw(raw), .tilt(tilt), .over_l(over_l), .over_r(over_r)
  );

  osd_debounce #(.CNT_W(CNT_W)) u_deb (
    .clk(clk), .rst(rst), .take(take), .tilt(tilt), .raw(raw), .lim(orc_lim),
    .cur_q(orient_cur), .prev_q(orient_prev), .tilt_q(tilt_bad), .chg_ev(chg_ev)
  );

  osd_shake #(.CNT_W(CNT_W)) u_shk (
    .clk(clk), .rst(rst), .take(take), .over_l(over_l), .over_r(over_r),
    .lim(shc_lim), .shk_ev(shk_ev), .shk_dir(shk_dir)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq        <= 1'b0;
      shake_code <= SHK_NONE;
    end else begin
      irq <= (irq && !int_clr) || chg_ev || shk_ev;
      if (shk_ev)       shake_code <= shk_dir;
      else if (int_clr) shake_code <= SHK_NONE;
    end
  end

  a_r6_code_legal: assert property (@(posedge clk) disable iff (rst)
    shake_code != 2'b11);
  a_r9_irq_sticky: assert property (@(posedge clk) disable iff (rst)
    irq && !int_clr |=> irq);
  a_r9_change_raises_irq: assert property (@(posedge clk) disable iff (rst)
    !$stable(orient_cur) |-> irq);
  a_r8_pd_freeze: assert property (@(posedge clk) disable iff (rst)
    pwr_down |=> $stable(orient_cur) && $stable(orient_prev) && $stable(tilt_bad));
endmodule

// File: tb/orient_shake_det_tb_top.sv
module orient_shake_det_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_valid = 1'b0, pwr_down = 1'b0, int_clr = 1'b0;
  logic [7:0] x_in = '0, y_in = '0;
  logic [1:0] orc_sel = '0, shth_sel = '0, shc_sel = '0;
  logic [1:0] orient_cur, orient_prev, shake_code;
  logic tilt_bad, irq;

  int checks = 0, fails = 0;
  int m_cur, m_prev, m_cand, m_cnt, m_tilt, m_sdir, m_scnt, m_irq, m_code;

  always #4 clk = ~clk;

  orient_shake_det dut_i (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .x_in(x_in), .y_in(y_in),
    .pwr_down(pwr_down), .orc_sel(orc_sel), .shth_sel(shth_sel), .shc_sel(shc_sel),
    .int_clr(int_clr), .orient_cur(orient_cur), .orient_prev(orient_prev),
    .tilt_bad(tilt_bad), .shake_code(shake_code), .irq(irq)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  // reference behaviour, from the requirements
  task automatic model(input bit v, input int xv, input int yv, input bit pd, input bit clr);
    int ax, ay, raw, thr, d, nl, sl;
    bit t, ev_o, ev_s;
    ax = (xv < 0) ? -xv : xv;
    ay = (yv < 0) ? -yv : yv;
    t = (ax < 32) && (ay < 32);
    if (ay >= ax) raw = (yv < 0) ? 2 : 0;
    else          raw = (xv < 0) ? 3 : 1;
    thr = 32 * (int'(shth_sel) + 1);
    d = (xv < -thr) ? 1 : ((xv > thr) ? 2 : 0);
    nl = 16 << orc_sel;
    sl = 16 << shc_sel;
    ev_o = 0; ev_s = 0;
    if (v && !pd) begin
      m_tilt = t;
      if (!t) begin
        if (raw == m_cur) m_cnt = 0;
        else if (raw == m_cand) begin
          m_cnt++;
          if (m_cnt >= nl) begin m_prev = m_cur; m_cur = raw; m_cnt = 0; ev_o = 1; end
        end else begin m_cand = raw; m_cnt = 1; end
      end
      if (d != 0) begin
        if (d == m_sdir) m_scnt++;
        else begin m_sdir = d; m_scnt = 1; end
        if (m_scnt >= sl) begin ev_s = 1; m_scnt = 0; end
      end else m_scnt = 0;
    end
    if (clr) begin m_irq = 0; m_code = 0; end
    if (ev_o || ev_s) m_irq = 1;
    if (ev_s) m_code = d;
  endtask

  task automatic step(input bit v, input int xv, input int yv, input bit pd, input bit clr);
    smp_valid = v; x_in = 8'(xv); y_in = 8'(yv); pwr_down = pd; int_clr = clr;
    @(posedge clk);
    model(v, xv, yv, pd, clr);
    @(negedge clk);
    smp_valid = 0; int_clr = 0;
    chk(orient_cur,  m_cur,  "R3 orient_cur vs model");
    chk(orient_prev, m_prev, "R4 orient_prev vs model");
    chk(tilt_bad,    m_tilt, "R5 tilt_bad vs model");
    chk(shake_code,  m_code, "R7 shake_code vs model");
    chk(irq,         m_irq,  "R9 irq vs model");
  endtask

  task automatic feed(input int n, input int xv, input int yv);
    for (int i = 0; i < n; i++) step(1, xv, yv, 0, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all-R actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int held;
    logic [31:0] r;
    m_cur = 0; m_prev = 0; m_cand = 0; m_cnt = 0; m_tilt = 0;
    m_sdir = 0; m_scnt = 0; m_irq = 0; m_code = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(orient_cur, 0, "R1 orient_cur"); chk(orient_prev, 0, "R1 orient_prev");
    chk(tilt_bad, 0, "R1 tilt_bad"); chk(shake_code, 0, "R1 shake_code"); chk(irq, 0, "R1 irq");

    // R2/R3 quadrants, shake disabled via unreachable threshold (R6)
    shth_sel = 2'd3; orc_sel = 2'd0;
    feed(15, 100, 0);   chk(orient_cur, 0, "R3 no change after 15");
    feed(1, 100, 0);    chk(orient_cur, 1, "R2 +X cw"); chk(orient_prev, 0, "R4 prev");
    chk(irq, 1, "R9 irq on change"); chk(shake_code, 0, "R6 threshold 128 unreachable");
    feed(16, 0, -100);  chk(orient_cur, 2, "R2 -Y inverted"); chk(orient_prev, 1, "R4 prev");
    feed(16, -100, 0);  chk(orient_cur, 3, "R2 -X ccw");
    feed(16, 50, 50);   chk(orient_cur, 0, "R2 tie to Y up");
    feed(16, -40, -40); chk(orient_cur, 2, "R2 tie to Y inverted");
    // R5 tilt readings pause the run
    feed(8, 100, 5);
    feed(5, 10, -20);   chk(tilt_bad, 1, "R5 tilt set"); chk(orient_cur, 2, "R5 hold");
    feed(7, 100, 5);    chk(orient_cur, 2, "R5 run paused 15"); chk(tilt_bad, 0, "R5 tilt clear");
    feed(1, 100, 5);    chk(orient_cur, 1, "R5 run completes at 16");
    // R3 interrupted run restarts
    feed(10, 0, -100);
    feed(1, 0, 100);
    feed(15, 0, -100);  chk(orient_cur, 1, "R3 restart 15");
    feed(1, 0, -100);   chk(orient_cur, 2, "R3 restart 16");
    // R3 longer run code
    orc_sel = 2'd1;
    feed(31, -100, 0);  chk(orient_cur, 2, "R3 sel1 31");
    feed(1, -100, 0);   chk(orient_cur, 3, "R3 sel1 32");

    // R6/R7 shakes
    shth_sel = 2'd0; shc_sel = 2'd0;
    step(0, 0, 0, 0, 1); chk(irq, 0, "R9 clear"); chk(shake_code, 0, "R9 code clear");
    feed(15, -33, 0);   chk(shake_code, 0, "R7 left 15");
    feed(1, -33, 0);    chk(shake_code, 1, "R6 left code"); chk(irq, 1, "R9 shake irq");
    step(0, 0, 0, 0, 1);
    feed(20, -32, 0);   chk(shake_code, 0, "R6 at threshold no count"); chk(irq, 0, "R6 no irq");
    feed(16, 40, 0);    chk(shake_code, 2, "R6 right code");
    step(0, 0, 0, 0, 1);
    feed(10, 40, 0);
    feed(1, -40, 0);
    feed(15, 40, 0);    chk(shake_code, 0, "R7 reversal restarts"); chk(irq, 0, "R7 no irq");
    step(1, 40, 0, 0, 1); chk(shake_code, 2, "R9 event beats clear"); chk(irq, 1, "R9 set wins");

    // R8 power down, R10 invalid
    step(0, 0, 0, 0, 1);
    held = int'(orient_cur);
    for (int i = 0; i < 70; i++) step(1, 0, 100, 1, 0);
    chk(orient_cur, held, "R8 pd orient hold"); chk(irq, 0, "R8 pd no irq");
    for (int i = 0; i < 70; i++) step(0, 0, 100, 0, 0);
    chk(orient_cur, held, "R10 invalid ignored"); chk(irq, 0, "R10 no irq");

    // near-exhaustive sweep, smallest configuration (R2 R5 R6)
    orc_sel = 0; shc_sel = 0; shth_sel = 0;
    for (int xv = -128; xv < 128; xv++)
      for (int yv = -128; yv < 128; yv++)
        step(1, xv, yv, 0, (yv == 0));

    // pseudo-random runs over all configurations (R3 R7 R8 R9)
    r = 32'h1234_5678;
    for (int k = 0; k < 1400; k++) begin
      r ^= r << 13; r ^= r >> 17; r ^= r << 5;
      if (r[31:29] == 3'd0) begin orc_sel = r[23:22]; shc_sel = r[25:24]; shth_sel = r[27:26]; end
      for (int j = 0; j <= int'(r[20:16]); j++)
        step(r[28:26] != 3'd0, $signed(r[7:0]), $signed(r[15:8]),
             r[11:9] == 3'd0 && j < 2, j == 0 && r[21]);
    end

    summary();
    $finish;
  end
endmodule